// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic core of a small accumulator machine. It holds an accumulator byte, a second operand/extension byte, and a four-flag status register. On every clock edge where an operation is presented, it updates these registers. The operations cover binary add with and without carry-in, subtract with borrow, packed-BCD correction after an add, 8x8 unsigned multiply, 8/8 unsigned divide, four rotate variants, and a nibble exchange.

A sequencer outside the block owns instruction decoding and operand fetch. That sequencer drives an operation code and a source byte for one cycle. Results and flags appear on the outputs right after the edge that accepts the operation. Load codes let the sequencer place values into the accumulator and the extension byte. Other codes set or clear the carry flag.

Top module: `byte_alu_flags`

## Requirements
- R1: While reset is low, and right after it, the accumulator, the extension byte and every flag read zero. The status bits are 3 carry, 2 auxiliary carry, 1 overflow and 0 parity.
- R2: Code 5 (add) writes A+src to the accumulator. Code 6 (add with carry) writes A+src+carry. Carry becomes the carry out of bit 7.
- R3: Code 7 (subtract with borrow) writes A-src-carry modulo 256. Carry becomes 1 exactly when that difference is negative.
- R4: For codes 5, 6 and 7, auxiliary carry becomes the carry (or borrow) from bit 3 into bit 4.
- R5: For codes 5, 6 and 7, overflow becomes 1 exactly when the signed two's-complement result lies outside -128..127.
- R6: The parity flag always makes the count of ones in the accumulator plus the flag even, whatever the last operation was.
- R7: Code 8 (decimal adjust) first adds 0x06 if the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 if the high nibble exceeds 9 or a carry is set or pending. Carry is set if it was set or if either step carried out. Overflow and auxiliary carry keep their values.
- R8: Code 9 (multiply) puts the low product byte in the accumulator and the high byte in the extension byte. It clears carry and sets overflow exactly when the product exceeds 0xFF.
- R9: Code 10 (divide) with a nonzero extension byte puts the quotient of A by that byte in the accumulator and the remainder in the extension byte. It clears carry and overflow.
- R10: Code 10 with a zero extension byte sets overflow and clears carry. The accumulator and the extension byte keep their values.
- R11: Code 11 rotates left and code 13 rotates right; both leave carry alone. Code 12 rotates left through carry and code 14 rotates right through carry (a 9-bit ring).
- R12: Code 15 exchanges the accumulator nibbles. Codes 1 and 2 load src into the accumulator and the extension byte. Codes 3 and 4 clear and set carry. Code 0, or any code with opValid low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 4 | Operation selector (codes in R2..R12) |
| srcByte | input | 8 | Source operand |
| accOut | output | 8 | Accumulator register |
| bOut | output | 8 | Extension byte register |
| statusOut | output | 4 | {carry, auxiliary carry, overflow, parity} |

## Verification
The embedded properties assume reset is held low across at least one rising edge. They also assume that every opCode seen with opValid high is a defined, unknown-free 4-bit value, so that at most one unit strobe fires per cycle. The bench changes its inputs only on falling edges. It presents exactly one operation per cycle and ends each sequence with opValid low, so no operation repeats by accident. Divide stimulus deliberately includes a zero extension byte so that the overflow-only path is reached.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP    = 4'd0,
    OP_LDA    = 4'd1,
    OP_LDB    = 4'd2,
    OP_CLRC   = 4'd3,
    OP_SETC   = 4'd4,
    OP_ADD    = 4'd5,
    OP_ADDC   = 4'd6,
    OP_SUBB   = 4'd7,
    OP_DECADJ = 4'd8,
    OP_MUL    = 4'd9,
    OP_DIV    = 4'd10,
    OP_ROL    = 4'd11,
    OP_ROLC   = 4'd12,
    OP_ROR    = 4'd13,
    OP_RORC   = 4'd14,
    OP_SWAP   = 4'd15
  } aluOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doAddSub;
    logic subMode;
    logic useCarry;
    logic doDecAdj;
    logic doMul;
    logic doDiv;
    logic doRot;
    logic rotRight;
    logic rotThru;
    logic doSwap;
    logic loadA;
    logic loadB;
    logic doCarryWr;
    logic carryVal;
  } aluStrobe_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import byte_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       opValid,
  input  aluOp_e     opCode,
  output aluStrobe_t strb
);

  always_comb begin
    strb = '0;
    if (opValid) begin
      unique case (opCode)
        OP_NOP:    ;
        OP_LDA:    strb.loadA = 1'b1;
        OP_LDB:    strb.loadB = 1'b1;
        OP_CLRC:   begin strb.doCarryWr = 1'b1; strb.carryVal = 1'b0; end
        OP_SETC:   begin strb.doCarryWr = 1'b1; strb.carryVal = 1'b1; end
        OP_ADD:    strb.doAddSub = 1'b1;
        OP_ADDC:   begin strb.doAddSub = 1'b1; strb.useCarry = 1'b1; end
        OP_SUBB:   begin strb.doAddSub = 1'b1; strb.useCarry = 1'b1; strb.subMode = 1'b1; end
        OP_DECADJ: strb.doDecAdj = 1'b1;
        OP_MUL:    strb.doMul = 1'b1;
        OP_DIV:    strb.doDiv = 1'b1;
        OP_ROL:    strb.doRot = 1'b1;
        OP_ROLC:   begin strb.doRot = 1'b1; strb.rotThru = 1'b1; end
        OP_ROR:    begin strb.doRot = 1'b1; strb.rotRight = 1'b1; end
        OP_RORC:   begin strb.doRot = 1'b1; strb.rotRight = 1'b1; strb.rotThru = 1'b1; end
        OP_SWAP:   strb.doSwap = 1'b1;
        default:   strb = '0;
      endcase
    end
  end

  // at most one unit claims the registers in a cycle
  assert_single_unit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.doAddSub, strb.doDecAdj, strb.doMul, strb.doDiv, strb.doRot,
              strb.doSwap, strb.loadA, strb.loadB, strb.doCarryWr}));

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  input  logic              cIn,
  input  logic              subMode,
  output logic [DATA_W-1:0] resOut,
  output logic              carryOut,
  output logic              auxOut,
  output logic              ovfOut
);

  localparam int NIB_W = DATA_W / 2;

  logic [DATA_W:0] wideA, wideB, wideC, wideRes;
  logic [NIB_W:0]  nibA, nibB, nibC, nibRes;

  always_comb begin
    wideA = {1'b0, aIn};
    wideB = {1'b0, bIn};
    wideC = {{DATA_W{1'b0}}, cIn};
    nibA  = {1'b0, aIn[NIB_W-1:0]};
    nibB  = {1'b0, bIn[NIB_W-1:0]};
    nibC  = {{NIB_W{1'b0}}, cIn};
    if (subMode) begin
      wideRes = wideA - wideB - wideC;
      nibRes  = nibA - nibB - nibC;
      ovfOut  = (aIn[DATA_W-1] != bIn[DATA_W-1]) && (wideRes[DATA_W-1] != aIn[DATA_W-1]);
    end else begin
      wideRes = wideA + wideB + wideC;
      nibRes  = nibA + nibB + nibC;
      ovfOut  = (aIn[DATA_W-1] == bIn[DATA_W-1]) && (wideRes[DATA_W-1] != aIn[DATA_W-1]);
    end
    resOut   = wideRes[DATA_W-1:0];
    carryOut = wideRes[DATA_W];
    auxOut   = nibRes[NIB_W];
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluStrobe_t        strb,
  input  logic [DATA_W-1:0] srcByte,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic [3:0]        statusOut
);

  localparam int NIB_W  = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam logic [DATA_W:0] ADJ_LO = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] ADJ_HI = ADJ_LO << NIB_W;
  localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);

  logic [DATA_W-1:0] accReg, bReg, accNext, bNext;
  logic cyReg, acReg, ovReg, parReg;
  logic cyNext, acNext, ovNext;

  // add / subtract unit
  logic [DATA_W-1:0] asRes;
  logic asCarry, asAux, asOvf, asCin;
  assign asCin = strb.useCarry & cyReg;

  alu_addsub #(.DATA_W(DATA_W)) uAddSub (
    .aIn     (accReg),
    .bIn     (srcByte),
    .cIn     (asCin),
    .subMode (strb.subMode),
    .resOut  (asRes),
    .carryOut(asCarry),
    .auxOut  (asAux),
    .ovfOut  (asOvf)
  );

  // decimal adjust: two chained correction adds
  logic lowFix, highFix, daCarry;
  logic [DATA_W:0] daStage1, daStage2;
  always_comb begin
    lowFix   = (accReg[NIB_W-1:0] > BCD_MAX) || acReg;
    daStage1 = {1'b0, accReg} + (lowFix ? ADJ_LO : '0);
    highFix  = (daStage1[DATA_W-1:NIB_W] > BCD_MAX) || cyReg || daStage1[DATA_W];
    daStage2 = daStage1 + (highFix ? ADJ_HI : '0);
    daCarry  = cyReg | daStage1[DATA_W] | daStage2[DATA_W];
  end

  // multiply and divide
  logic [PROD_W-1:0] prod;
  logic [DATA_W-1:0] divisor, quot, remd;
  logic divByZero;
  always_comb begin
    prod      = PROD_W'(accReg) * PROD_W'(bReg);
    divByZero = (bReg == '0);
    divisor   = divByZero ? DATA_W'(1) : bReg;
    quot      = accReg / divisor;
    remd      = accReg % divisor;
  end

  // next-state select
  always_comb begin
    accNext = accReg;
    bNext   = bReg;
    cyNext  = cyReg;
    acNext  = acReg;
    ovNext  = ovReg;
    if (strb.doAddSub) begin
      accNext = asRes;
      cyNext  = asCarry;
      acNext  = asAux;
      ovNext  = asOvf;
    end else if (strb.doDecAdj) begin
      accNext = daStage2[DATA_W-1:0];
      cyNext  = daCarry;
    end else if (strb.doMul) begin
      accNext = prod[DATA_W-1:0];
      bNext   = prod[PROD_W-1:DATA_W];
      cyNext  = 1'b0;
      ovNext  = |prod[PROD_W-1:DATA_W];
    end else if (strb.doDiv) begin
      cyNext = 1'b0;
      if (divByZero) begin
        ovNext = 1'b1;
      end else begin
        accNext = quot;
        bNext   = remd;
        ovNext  = 1'b0;
      end
    end else if (strb.doRot) begin
      unique case ({strb.rotRight, strb.rotThru})
        2'b00: accNext = {accReg[DATA_W-2:0], accReg[DATA_W-1]};
        2'b01: begin
          accNext = {accReg[DATA_W-2:0], cyReg};
          cyNext  = accReg[DATA_W-1];
        end
        2'b10: accNext = {accReg[0], accReg[DATA_W-1:1]};
        default: begin
          accNext = {cyReg, accReg[DATA_W-1:1]};
          cyNext  = accReg[0];
        end
      endcase
    end else if (strb.doSwap) begin
      accNext = {accReg[NIB_W-1:0], accReg[DATA_W-1:NIB_W]};
    end else if (strb.loadA) begin
      accNext = srcByte;
    end else if (strb.loadB) begin
      bNext = srcByte;
    end else if (strb.doCarryWr) begin
      cyNext = strb.carryVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accReg <= '0;
      bReg   <= '0;
      cyReg  <= 1'b0;
      acReg  <= 1'b0;
      ovReg  <= 1'b0;
      parReg <= 1'b0;
    end else begin
      accReg <= accNext;
      bReg   <= bNext;
      cyReg  <= cyNext;
      acReg  <= acNext;
      ovReg  <= ovNext;
      parReg <= ^accNext;
    end
  end

  assign accOut    = accReg;
  assign bOut      = bReg;
  assign statusOut = {cyReg, acReg, ovReg, parReg};

  assert_parity_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (^{accReg, parReg}) == 1'b0);

  assert_mul_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.doMul |=> (!cyReg && (ovReg == (bReg != '0))));

  assert_div_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doDiv && bReg != '0) |=> (!cyReg && !ovReg));

  assert_div_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doDiv && bReg == '0) |=> (ovReg && !cyReg && $stable(accReg) && $stable(bReg)));

  assert_rot_carry_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.doRot && !strb.rotThru) |=> $stable(cyReg));

endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
  import byte_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] srcByte,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic [3:0]        statusOut
);

  aluStrobe_t strb;

  alu_ctrl uCtrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opValid(opValid),
    .opCode (aluOp_e'(opCode)),
    .strb   (strb)
  );

  alu_datapath #(.DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .srcByte  (srcByte),
    .accOut   (accOut),
    .bOut     (bOut),
    .statusOut(statusOut)
  );

endmodule

// File: tb/tb_byte_alu_flags.sv
`timescale 1ns/1ps
module tb_byte_alu_flags;
  import byte_alu_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic opValid = 1'b0;
  logic [3:0] opCode = 4'd0;
  logic [7:0] srcByte = 8'd0;
  logic [7:0] accOut, bOut;
  logic [3:0] statusOut;

  always #2.5 clk = ~clk;

  byte_alu_flags dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .srcByte(srcByte), .accOut(accOut), .bOut(bOut), .statusOut(statusOut)
  );

  typedef struct {
    logic [7:0] a;
    logic [7:0] b;
    logic [3:0] st;
    string      req;
  } expItem_t;

  expItem_t expQ[$];
  int numTests = 0;
  int numFail  = 0;
  int mA = 0, mB = 0;
  bit mC = 0, mAC = 0, mOV = 0;

  function automatic string reqOf(input logic [3:0] op, input bit valid);
    if (!valid) return "R12";
    case (op)
      4'd5, 4'd6: return "R2 R4 R5 R6";
      4'd7:       return "R3 R4 R5 R6";
      4'd8:       return "R7 R6";
      4'd9:       return "R8 R6";
      4'd10:      return "R9 R10";
      4'd11, 4'd12, 4'd13, 4'd14: return "R11 R6";
      default:    return "R12";
    endcase
  endfunction

  function automatic int toSigned(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  task automatic applyModel(input logic [3:0] op, input int src);
    int ci, s, lo, sr, t, p, nc;
    bit c;
    case (op)
      4'd1: mA = src;
      4'd2: mB = src;
      4'd3: mC = 0;
      4'd4: mC = 1;
      4'd5, 4'd6: begin
        ci = (op == 4'd6) ? int'(mC) : 0;
        s  = mA + src + ci;
        lo = (mA % 16) + (src % 16) + ci;
        sr = toSigned(mA) + toSigned(src) + ci;
        mAC = (lo > 15); mOV = (sr > 127 || sr < -128); mC = (s > 255);
        mA = s % 256;
      end
      4'd7: begin
        ci = int'(mC);
        s  = mA - src - ci;
        lo = (mA % 16) - (src % 16) - ci;
        sr = toSigned(mA) - toSigned(src) - ci;
        mAC = (lo < 0); mOV = (sr > 127 || sr < -128); mC = (s < 0);
        mA = (s + 256) % 256;
      end
      4'd8: begin
        t = mA; c = mC;
        if ((t % 16) > 9 || mAC) t = t + 6;
        if (t > 255) c = 1;
        if (((t / 16) % 16) > 9 || c) t = t + 96;
        if (t > 255) c = 1;
        mA = t % 256; mC = c;
      end
      4'd9: begin
        p = mA * mB;
        mA = p % 256; mB = p / 256; mOV = (p > 255); mC = 0;
      end
      4'd10: begin
        mC = 0;
        if (mB == 0) mOV = 1;
        else begin t = mA; mA = t / mB; mB = t % mB; mOV = 0; end
      end
      4'd11: mA = ((mA * 2) % 256) + (mA / 128);
      4'd12: begin nc = mA / 128; mA = ((mA * 2) % 256) + int'(mC); mC = nc[0]; end
      4'd13: mA = (mA / 2) + (mA % 2) * 128;
      4'd14: begin nc = mA % 2; mA = (mA / 2) + int'(mC) * 128; mC = nc[0]; end
      4'd15: mA = (mA % 16) * 16 + (mA / 16);
      default: ;
    endcase
  endtask

  task automatic drive(input logic [3:0] op, input logic [7:0] src, input bit valid);
    expItem_t it;
    logic [7:0] a8;
    @(negedge clk);
    if (valid) applyModel(op, int'(src));
    a8 = mA[7:0];
    opValid = valid; opCode = op; srcByte = src;
    it.a = a8; it.b = mB[7:0];
    it.st = {mC, mAC, mOV, ^a8};
    it.req = reqOf(op, valid);
    expQ.push_back(it);
  endtask

  // monitor: compare each result one step after its edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        numTests++;
        if (accOut !== it.a || bOut !== it.b || statusOut !== it.st) begin
          numFail++;
          $display("FAIL %s: actual A=%h B=%h st=%b expected A=%h B=%h st=%b",
                   it.req, accOut, bOut, statusOut, it.a, it.b, it.st);
        end
      end
    end
  end

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", numTests, numFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    numFail++;
    $display("FAIL R1 watchdog: actual=hung expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    numTests++;
    if (accOut !== 8'h00 || bOut !== 8'h00 || statusOut !== 4'b0000) begin
      numFail++;
      $display("FAIL R1: actual A=%h B=%h st=%b expected A=00 B=00 st=0000", accOut, bOut, statusOut);
    end
    rst_n = 1'b1;

    // R2 R5: 0x63 + 0x23 -> 0x86, C0 OV1 P1
    drive(OP_LDA, 8'h63, 1); drive(OP_ADD, 8'h23, 1);
    // R2 R4: 0x0F + 0xFF -> 0x0E with carry and aux carry
    drive(OP_LDA, 8'h0F, 1); drive(OP_ADD, 8'hFF, 1);
    drive(OP_ADDC, 8'h10, 1);
    // R3: subtract with borrow, carry cleared then set
    drive(OP_CLRC, 8'h00, 1); drive(OP_LDA, 8'h10, 1); drive(OP_SUBB, 8'h01, 1);
    drive(OP_SUBB, 8'h20, 1); drive(OP_LDA, 8'h80, 1); drive(OP_CLRC, 8'h00, 1);
    drive(OP_SUBB, 8'h01, 1);
    // R7: 0x59 + 1 adjusted to 0x60; 0x99 + 1 adjusted to 0x00 with carry
    drive(OP_LDA, 8'h59, 1); drive(OP_ADD, 8'h01, 1); drive(OP_DECADJ, 8'h00, 1);
    drive(OP_LDA, 8'h99, 1); drive(OP_ADD, 8'h01, 1); drive(OP_DECADJ, 8'h00, 1);
    // R8: 0x55 * 0x22 = 0x0B4A, then small product
    drive(OP_LDA, 8'h55, 1); drive(OP_LDB, 8'h22, 1); drive(OP_MUL, 8'h00, 1);
    drive(OP_LDA, 8'h07, 1); drive(OP_LDB, 8'h09, 1); drive(OP_MUL, 8'h00, 1);
    // R9: 0xFB / 0x12 = 0x0D rem 0x11
    drive(OP_LDA, 8'hFB, 1); drive(OP_LDB, 8'h12, 1); drive(OP_DIV, 8'h00, 1);
    // R10: divide by zero
    drive(OP_LDA, 8'h3C, 1); drive(OP_LDB, 8'h00, 1); drive(OP_SETC, 8'h00, 1);
    drive(OP_DIV, 8'h00, 1);
    // R11: A=0, C=1, rotate right through carry -> 0x80, C0
    drive(OP_LDA, 8'h00, 1); drive(OP_SETC, 8'h00, 1); drive(OP_RORC, 8'h00, 1);
    drive(OP_ROL, 8'h00, 1); drive(OP_ROR, 8'h00, 1); drive(OP_ROLC, 8'h00, 1);
    // R12: swap, and no effect with opValid low or code 0
    drive(OP_LDA, 8'hA7, 1); drive(OP_SWAP, 8'h00, 1);
    drive(OP_LDA, 8'hFF, 0); drive(OP_NOP, 8'h55, 1);

    // mixed stream
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic [7:0] sv;
      op = 4'($urandom_range(0, 15));
      sv = 8'($urandom);
      if (op == OP_LDB && $urandom_range(0, 3) == 0) sv = 8'h00;
      drive(op, sv, ($urandom_range(0, 9) != 0));
    end
    drive(OP_NOP, 8'h00, 0);
    repeat (4) @(posedge clk);
    #1;
    finishRun();
  end

endmodule